// File: doc/BRIEF.md
# Parallel-Lane Dot Data Shifter

This block collects the on/off pattern for one line of a thermal print head. Eight data lanes run side by side. On each shift clock edge a full byte enters the first of six byte-wide stages, and every stage passes its byte on to the next one. After six loads the chain holds 48 dot bits. These bits drive the head directly, and a set bit means that dot is heated.

The same 8-bit data bus also carries a gray-scale duty value. A select input chooses what the bus does. In dot mode the bus feeds the chain. In gray mode the chain is frozen and the low four bits are captured into a small register for a separate duty stage. Pulling the write enable low also freezes the pattern, so the outputs hold steady with no separate latch strobe.

Reset asserts asynchronously and clears everything. Its release is synchronised to the shift clock by a two-stage synchroniser.

Top module: `dot_shifter_top`

## Requirements
- R1: While `rst_n` is low, `dots` and `gray_val` are all zero, and they clear without waiting for a clock edge.
- R2: On a rising `clk` edge with `wr_en` = 1 and `dat_sel` = 1, block 1 (`dots[7:0]`) takes `din`, and each block k+1 takes the old content of block k.
- R3: Block k (k = 1..6) occupies `dots[8k-1:8k-8]`, and lane j of `din` lands on bit j of that block. A 1 drives the dot and a 0 leaves it off.
- R4: The first byte of six consecutive shifts sits in block 6 (`dots[47:40]`), and the most recent byte sits in block 1.
- R5: With `wr_en` = 0, clock edges leave `dots` unchanged whatever `din` carries.
- R6: With `dat_sel` = 0 (gray mode), a rising edge loads `din[3:0]` into `gray_val` and leaves `dots` unchanged, even with `wr_en` = 1.
- R7: With `dat_sel` = 1, `gray_val` keeps its value across edges.
- R8: In gray mode, `din[7:4]` has no effect on `gray_val`.
- R9: After `rst_n` rises, the first two rising clock edges change nothing. The third edge is the first one that can shift or load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; all state updates on its rising edge |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases through a synchroniser |
| din | input | 8 | Parallel dot byte, or gray value on the low four bits |
| wr_en | input | 1 | Clock enable for the shift chain; low freezes the pattern |
| dat_sel | input | 1 | 1 = dot shifting, 0 = gray value load |
| dots | output | 48 | Dot pattern, block 1 in the low byte |
| gray_val | output | 4 | Captured gray-scale duty value |

## Verification
The bench aims at the mode boundaries. It shifts with `wr_en` high while in gray mode, which a design that ignored the select would use to corrupt the pattern. It puts nonzero values on the upper bus bits while loading the gray value, which would show a lane mixup. It checks the six-shift ordering bit by bit, so a design that reversed the chain or lane order shows the newest byte at the far end. It also drives shifts during the two edges after reset release, and it drops reset between edges to prove the clear does not wait for a clock.

// File: rtl/dot_shifter_pkg.sv
package dot_shifter_pkg;
  localparam int unsigned DS_LANES  = 8;
  localparam int unsigned DS_STAGES = 6;
  localparam int unsigned DS_GRAY_W = 4;
  localparam int unsigned DS_SYNC_N = 2;

  typedef enum logic {
    SEL_GRAY = 1'b0,
    SEL_DOTS = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/dot_rst_sync.sv
module dot_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic core_rst_n
);
  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign core_rst_n = sync_q[DEPTH-1];
endmodule

// File: rtl/dot_byte_stage.sv
module dot_byte_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/dot_gray_reg.sv
module dot_gray_reg #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    q_nxt = load ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/dot_shifter_top.sv
module dot_shifter_top
  import dot_shifter_pkg::*;
#(
  parameter int unsigned LANES  = DS_LANES,
  parameter int unsigned STAGES = DS_STAGES,
  parameter int unsigned GRAY_W = DS_GRAY_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        din,
  input  logic                    wr_en,
  input  logic                    dat_sel,
  output logic [LANES*STAGES-1:0] dots,
  output logic [GRAY_W-1:0]       gray_val
);
  localparam int unsigned DOT_W = LANES * STAGES;

  logic      core_rst_n;
  logic      shift_en;
  logic      gray_ld;
  sel_mode_e mode;

  logic [LANES-1:0] chain [STAGES+1];

  dot_rst_sync #(.DEPTH(DS_SYNC_N)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_rst_n (core_rst_n)
  );

  always_comb begin
    mode     = sel_mode_e'(dat_sel);
    shift_en = wr_en && (mode == SEL_DOTS);
    gray_ld  = (mode == SEL_GRAY);
  end

  assign chain[0] = din;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    dot_byte_stage #(.WIDTH(LANES)) u_stage (
      .clk   (clk),
      .rst_n (core_rst_n),
      .en    (shift_en),
      .d     (chain[g]),
      .q     (chain[g+1])
    );
    assign dots[g*LANES +: LANES] = chain[g+1];
  end

  dot_gray_reg #(.WIDTH(GRAY_W)) u_gray (
    .clk   (clk),
    .rst_n (core_rst_n),
    .load  (gray_ld),
    .d     (din[GRAY_W-1:0]),
    .q     (gray_val)
  );
endmodule

// File: rtl/dot_shifter_chk.sv
module dot_shifter_chk #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned STAGES = 6,
  parameter int unsigned GRAY_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    core_rst_n,
  input logic [LANES-1:0]        din,
  input logic                    wr_en,
  input logic                    dat_sel,
  input logic [LANES*STAGES-1:0] dots,
  input logic [GRAY_W-1:0]       gray_val
);
  localparam int unsigned DOT_W = LANES * STAGES;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (dots == '0 && gray_val == '0));

  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && dat_sel) |=> (dots[LANES-1:0] == $past(din) &&
                            dots[DOT_W-1:LANES] == $past(dots[DOT_W-LANES-1:0])));

  // R5
  write_hold_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !wr_en |=> $stable(dots));

  // R6
  gray_load_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !dat_sel |=> ($stable(dots) && gray_val == $past(din[GRAY_W-1:0])));

  // R7
  gray_hold_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    dat_sel |=> $stable(gray_val));
endmodule

bind dot_shifter_top dot_shifter_chk #(
  .LANES  (LANES),
  .STAGES (STAGES),
  .GRAY_W (GRAY_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .din        (din),
  .wr_en      (wr_en),
  .dat_sel    (dat_sel),
  .dots       (dots),
  .gray_val   (gray_val)
);

// File: tb/dot_shifter_top_tb_top.sv
module dot_shifter_top_tb_top;
  localparam int CLK_P  = 10;
  localparam int LANES  = 8;
  localparam int STAGES = 6;
  localparam int DOT_W  = LANES * STAGES;

  logic             clk;
  logic             rst_n;
  logic [LANES-1:0] din;
  logic             wr_en;
  logic             dat_sel;
  logic [DOT_W-1:0] dots;
  logic [3:0]       gray_val;

  int    n_chk;
  int    n_fail;
  bit    live;
  string tag;

  logic [7:0] mq [$];
  logic [3:0] m_gray;
  int         m_cnt;

  dot_shifter_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .wr_en    (wr_en),
    .dat_sel  (dat_sel),
    .dots     (dots),
    .gray_val (gray_val)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [DOT_W-1:0] exp_dots();
    logic [DOT_W-1:0] v = '0;
    for (int i = 0; i < STAGES; i++) v[i*LANES +: LANES] = mq[i];
    return v;
  endfunction

  // behavioural reference: mq[0] is block 1, newest byte at the front
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      for (int i = 0; i < STAGES; i++) mq.push_back(8'h00);
      m_gray = 4'h0;
      m_cnt  = 0;
    end else begin
      if (m_cnt >= 2) begin
        if (wr_en && dat_sel) begin
          mq.push_front(din);
          void'(mq.pop_back());
        end
        if (!dat_sel) m_gray = din[3:0];
      end
      if (m_cnt < 2) m_cnt++;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      check(tag, 64'(dots), 64'(exp_dots()));
      check(tag, 64'(gray_val), 64'(m_gray));
    end
  end

  task automatic drive(logic [7:0] d, logic w, logic s);
    @(negedge clk);
    din = d; wr_en = w; dat_sel = s;
  endtask

  initial begin
    #(CLK_P*100000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; live = 0; tag = "R1";
    din = '0; wr_en = 0; dat_sel = 1;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    #(CLK_P*3);
    check("R1", 64'(dots), 64'h0);
    check("R1", 64'(gray_val), 64'h0);
    live = 1;
    // R9: shifts offered during the two synchroniser edges must be lost
    tag = "R9";
    @(negedge clk);
    rst_n = 1'b1; din = 8'hAA; wr_en = 1; dat_sel = 1;
    drive(8'h55, 1, 1);
    drive(8'h11, 1, 1);
    @(negedge clk);
    check("R9", 64'(dots[7:0]), 64'h11);
    check("R9", 64'(dots[15:8]), 64'h00);
    // R2 / R4: six distinct bytes
    tag = "R2";
    drive(8'h01, 1, 1);
    drive(8'h02, 1, 1);
    drive(8'h04, 1, 1);
    drive(8'h08, 1, 1);
    drive(8'h10, 1, 1);
    drive(8'h80, 1, 1);
    drive(8'h3C, 0, 1);
    check("R4", 64'(dots[47:40]), 64'h01);
    check("R4", 64'(dots[7:0]), 64'h80);
    // R3: lane 7 of block 1 is dots[7]; lane 0 of block 6 is dots[40]
    check("R3", 64'(dots[7]), 64'h1);
    check("R3", 64'(dots[40]), 64'h1);
    check("R3", 64'(dots[41]), 64'h0);
    // R5: wr_en low, bus changing
    tag = "R5";
    for (int i = 0; i < 5; i++) drive(8'(8'hF0 ^ i), 0, 1);
    // R6 / R8: gray mode with write enabled and upper bits busy
    tag = "R6";
    drive(8'hA7, 1, 0);
    drive(8'h5C, 1, 0);
    tag = "R8";
    drive(8'hF3, 1, 0);
    @(negedge clk);
    check("R8", 64'(gray_val), 64'h3);
    // R7: back to dot mode, gray must hold
    tag = "R7";
    drive(8'h9E, 1, 1);
    drive(8'h61, 1, 1);
    @(negedge clk);
    check("R7", 64'(gray_val), 64'h3);
    // mixed traffic
    tag = "R2";
    for (int i = 0; i < 200; i++) drive(8'($urandom), 1'($urandom), 1'($urandom));
    // R1: asynchronous clear between edges
    drive(8'hFF, 1, 1);
    drive(8'hFF, 1, 1);
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1;
    check("R1", 64'(dots), 64'h0);
    check("R1", 64'(gray_val), 64'h0);
    tag = "R1";
    @(negedge clk);
    @(negedge clk);
    live = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule